// File: doc/BRIEF.md
# Pixel-Timed Greyscale Composite Renderer

This block turns a stored greyscale picture into the drive pattern for a three-pin resistor ladder that produces a monochrome composite video signal. The three pins feed resistors of unequal weight (roughly 270, 330 and 470 ohms), so each combination of driven-high pins gives a different output voltage. Driving all three low gives the sync level. Driving all three high would exceed the allowed signal range, so that combination never appears.

Timing is kept in dot units rather than raw clock cycles. A dot divider advances an X counter, and the X counter advances a Y counter. Every sync edge, serration gap and overscan boundary is therefore a dot position. The block issues a read address one dot ahead of the dot being shown, which covers the one-cycle latency of the external image memory. It then sorts each returned 4-bit grey code into one of six picture levels. The level bins are uneven and favour the lighter shades. The horizontal sync window sits at a nominal position plus a fixed shift that centres the picture on screen.

With the default parameters the block shows 256x240 active dots inside a 341-dot by 262-line frame. Each dot lasts 5 clocks. Horizontal sync starts at dot 262+15 and lasts 25 dots. Vertical sync covers lines 244 to 246.

Top module: `gcr_composite_top`

## Requirements
- R1: While reset is high, `pins` is the black pattern 3'b001 and `rd_addr` is 0. The counters rest on the last dot of the frame, so dot (0,0) begins CLKS_PER_DOT clocks after reset falls.
- R2: A dot lasts CLKS_PER_DOT clocks. A line has H_TOTAL dots and a frame has V_TOTAL lines, after which both counters wrap to 0.
- R3: Throughout a dot, `rd_addr` holds y*H_ACTIVE+x of the following dot when that dot lies inside the active area (x < H_ACTIVE, y < V_ACTIVE). Otherwise it is 0.
- R4: The pattern for a dot appears on `pins` one clock after the dot begins and holds for CLKS_PER_DOT clocks.
- R5: In the active area the grey code is binned as follows, with pins[2]=270 ohm, pins[1]=330 ohm and pins[0]=470 ohm: 0-1 to 001, 2-3 to 010, 4-6 to 100, 7-9 to 011, 10-12 to 101, 13-15 to 110.
- R6: On lines outside vertical sync, dots with HS_BASE+HS_SHIFT <= x < HS_BASE+HS_SHIFT+HS_LEN drive 3'b000.
- R7: On lines VS_START to VS_START+VS_LINES-1, the pins drive 3'b000 except inside the horizontal sync window, where they drive the black pattern 3'b001 as a serration gap.
- R8: Dots outside the active area that are in no sync interval drive the black pattern 3'b001.
- R9: `pins` never equals 3'b111.
- R10: A reset asserted in the middle of a frame returns the block to the state in R1, and the next frame then starts again at dot (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_data | input | 4 | Grey code returned by image memory, one clock after the address |
| rd_addr | output | AW ($clog2(H_ACTIVE*V_ACTIVE)) | Image memory read address for the next dot |
| pins | output | 3 | Resistor ladder drive: bit 2 = 270 ohm, bit 1 = 330 ohm, bit 0 = 470 ohm |

## Verification
`rd_addr` is a function of the current counters, so it is due in the same clock that a dot begins. The pin pattern for dot j is registered at the end of the dot's first clock, so it is due one clock later. For the n-th clock after reset falls, the bench therefore expects an address based on dot floor(n/CLKS_PER_DOT) and pins based on dot floor((n-1)/CLKS_PER_DOT), both counted from the last dot of the frame. It samples every clock at the falling edge. The bench stands in for the memory with a register that answers one clock after the address and holds a known code pattern, so every grey code reaches the binning logic.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    // Drive pattern for the ladder: bit 2 = 270 ohm, bit 1 = 330 ohm, bit 0 = 470 ohm
    typedef logic [2:0] pin_pat_t;

    localparam pin_pat_t PAT_SYNC  = 3'b000;
    localparam pin_pat_t PAT_BLACK = 3'b001;

    typedef enum logic [2:0] {
        LV_BLACK,   // 470 only
        LV_DIM,     // 330 only
        LV_MID,     // 270 only
        LV_LIGHT,   // 330 + 470
        LV_PALE,    // 270 + 470
        LV_WHITE    // 270 + 330
    } level_e;

    // Classification of the dot currently on screen
    typedef struct packed {
        logic hwin;    // inside horizontal sync window
        logic vline;   // on a vertical sync line
        logic active;  // inside visible picture
    } dot_class_t;

    // Uneven bins, weighted toward lighter shades
    function automatic level_e grey_to_level(input logic [3:0] code);
        level_e lv;
        if (code <= 4'd1)       lv = LV_BLACK;
        else if (code <= 4'd3)  lv = LV_DIM;
        else if (code <= 4'd6)  lv = LV_MID;
        else if (code <= 4'd9)  lv = LV_LIGHT;
        else if (code <= 4'd12) lv = LV_PALE;
        else                    lv = LV_WHITE;
        return lv;
    endfunction

    function automatic pin_pat_t level_to_pat(input level_e lv);
        pin_pat_t p;
        case (lv)
            LV_BLACK: p = 3'b001;
            LV_DIM:   p = 3'b010;
            LV_MID:   p = 3'b100;
            LV_LIGHT: p = 3'b011;
            LV_PALE:  p = 3'b101;
            LV_WHITE: p = 3'b110;
            default:  p = PAT_BLACK;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/gcr_dot_timer.sv
module gcr_dot_timer #(
    parameter int CLKS_PER_DOT = 5,
    parameter int H_TOTAL      = 341,
    parameter int V_TOTAL      = 262,
    localparam int PW  = (CLKS_PER_DOT > 1) ? $clog2(CLKS_PER_DOT) : 1,
    localparam int XCW = $clog2(H_TOTAL),
    localparam int YCW = $clog2(V_TOTAL)
) (
    input  logic           clk,
    input  logic           rst,
    output logic           phase_first,
    output logic           phase_last,
    output logic [XCW-1:0] cur_x,
    output logic [YCW-1:0] cur_y,
    output logic [XCW-1:0] nxt_x,
    output logic [YCW-1:0] nxt_y
);
    localparam logic [PW-1:0]  PH_LAST = PW'(CLKS_PER_DOT - 1);
    localparam logic [XCW-1:0] X_LAST  = XCW'(H_TOTAL - 1);
    localparam logic [YCW-1:0] Y_LAST  = YCW'(V_TOTAL - 1);

    logic [PW-1:0] phase;

    assign phase_first = (phase == '0);
    assign phase_last  = (phase == PH_LAST);

    // Position of the dot that follows the current one
    always_comb begin
        if (cur_x == X_LAST) begin
            nxt_x = '0;
            nxt_y = (cur_y == Y_LAST) ? '0 : cur_y + 1'b1;
        end else begin
            nxt_x = cur_x + 1'b1;
            nxt_y = cur_y;
        end
    end

    // Reset parks the counters on the final dot of the frame
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            cur_x <= X_LAST;
            cur_y <= Y_LAST;
        end else if (phase_last) begin
            phase <= '0;
            cur_x <= nxt_x;
            cur_y <= nxt_y;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/gcr_region.sv
module gcr_region
    import gcr_pkg::*;
#(
    parameter int H_TOTAL   = 341,
    parameter int V_TOTAL   = 262,
    parameter int H_ACTIVE  = 256,
    parameter int V_ACTIVE  = 240,
    parameter int HS_BASE   = 262,
    parameter int HS_SHIFT  = 15,
    parameter int HS_LEN    = 25,
    parameter int VS_START  = 244,
    parameter int VS_LINES  = 3,
    localparam int XCW = $clog2(H_TOTAL),
    localparam int YCW = $clog2(V_TOTAL),
    localparam int AW  = $clog2(H_ACTIVE * V_ACTIVE),
    localparam int XAW = (H_ACTIVE > 1) ? $clog2(H_ACTIVE) : 1
) (
    input  logic [XCW-1:0] cur_x,
    input  logic [YCW-1:0] cur_y,
    input  logic [XCW-1:0] nxt_x,
    input  logic [YCW-1:0] nxt_y,
    output dot_class_t     cls,
    output logic           look_active,
    output logic [AW-1:0]  rd_addr
);
    localparam int HW_LO = HS_BASE + HS_SHIFT;
    localparam int HW_HI = HW_LO + HS_LEN;
    localparam int VS_HI = VS_START + VS_LINES;
    localparam bit ACT_POW2 = ((H_ACTIVE & (H_ACTIVE - 1)) == 0);

    always_comb begin
        cls.hwin   = (int'(cur_x) >= HW_LO) && (int'(cur_x) < HW_HI);
        cls.vline  = (int'(cur_y) >= VS_START) && (int'(cur_y) < VS_HI);
        cls.active = (int'(cur_x) < H_ACTIVE) && (int'(cur_y) < V_ACTIVE);
    end

    assign look_active = (int'(nxt_x) < H_ACTIVE) && (int'(nxt_y) < V_ACTIVE);

    logic [AW-1:0] lin_addr;

    // Power-of-two row width packs the address; otherwise multiply
    generate
        if (ACT_POW2) begin : g_pack
            assign lin_addr = AW'((int'(nxt_y) << XAW) | int'(nxt_x));
        end else begin : g_mul
            assign lin_addr = AW'(int'(nxt_y) * H_ACTIVE + int'(nxt_x));
        end
    endgenerate

    assign rd_addr = look_active ? lin_addr : '0;
endmodule

// File: rtl/gcr_level_enc.sv
module gcr_level_enc
    import gcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       phase_first,
    input  dot_class_t cls,
    input  logic [3:0] rd_data,
    output pin_pat_t   pins
);
    pin_pat_t next_pat;

    always_comb begin
        if (cls.vline)
            next_pat = cls.hwin ? PAT_BLACK : PAT_SYNC;
        else if (cls.hwin)
            next_pat = PAT_SYNC;
        else if (cls.active)
            next_pat = level_to_pat(grey_to_level(rd_data));
        else
            next_pat = PAT_BLACK;
    end

    // Memory data for this dot is valid during its first clock
    always_ff @(posedge clk) begin
        if (rst)
            pins <= PAT_BLACK;
        else if (phase_first)
            pins <= next_pat;
    end
endmodule

// File: rtl/gcr_composite_top.sv
module gcr_composite_top
    import gcr_pkg::*;
#(
    parameter int CLKS_PER_DOT = 5,
    parameter int H_TOTAL      = 341,
    parameter int V_TOTAL      = 262,
    parameter int H_ACTIVE     = 256,
    parameter int V_ACTIVE     = 240,
    parameter int HS_BASE      = 262,
    parameter int HS_SHIFT     = 15,
    parameter int HS_LEN       = 25,
    parameter int VS_START     = 244,
    parameter int VS_LINES     = 3,
    localparam int AW = $clog2(H_ACTIVE * V_ACTIVE)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic [2:0]    pins
);
    localparam int XCW = $clog2(H_TOTAL);
    localparam int YCW = $clog2(V_TOTAL);

    logic           phase_first;
    logic           phase_last;
    logic [XCW-1:0] cur_x, nxt_x;
    logic [YCW-1:0] cur_y, nxt_y;
    dot_class_t     cls;
    logic           look_active;
    pin_pat_t       pat;

    gcr_dot_timer #(
        .CLKS_PER_DOT(CLKS_PER_DOT),
        .H_TOTAL     (H_TOTAL),
        .V_TOTAL     (V_TOTAL)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .phase_first(phase_first),
        .phase_last (phase_last),
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .nxt_x      (nxt_x),
        .nxt_y      (nxt_y)
    );

    gcr_region #(
        .H_TOTAL (H_TOTAL),
        .V_TOTAL (V_TOTAL),
        .H_ACTIVE(H_ACTIVE),
        .V_ACTIVE(V_ACTIVE),
        .HS_BASE (HS_BASE),
        .HS_SHIFT(HS_SHIFT),
        .HS_LEN  (HS_LEN),
        .VS_START(VS_START),
        .VS_LINES(VS_LINES)
    ) u_region (
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .nxt_x      (nxt_x),
        .nxt_y      (nxt_y),
        .cls        (cls),
        .look_active(look_active),
        .rd_addr    (rd_addr)
    );

    gcr_level_enc u_enc (
        .clk        (clk),
        .rst        (rst),
        .phase_first(phase_first),
        .cls        (cls),
        .rd_data    (rd_data),
        .pins       (pat)
    );

    assign pins = pat;
endmodule

// File: rtl/gcr_composite_chk.sv
module gcr_composite_chk
    import gcr_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    pins,
    input logic [AW-1:0] rd_addr,
    input logic          phase_first,
    input logic          phase_last,
    input dot_class_t    cls,
    input logic          look_active
);
    // R9
    no_all_high_chk: assert property (@(posedge clk) disable iff (rst)
        pins != 3'b111);

    // R4
    pins_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !phase_first |=> $stable(pins));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !phase_last |=> $stable(rd_addr));

    // R3
    addr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !look_active |-> rd_addr == '0);

    // R6
    hsync_low_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_first && !cls.vline && cls.hwin) |=> pins == 3'b000);

    // R7
    vsync_low_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_first && cls.vline && !cls.hwin) |=> pins == 3'b000);

    // R7
    serration_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_first && cls.vline && cls.hwin) |=> pins == 3'b001);

    // R1
    reset_black_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pins == 3'b001);
endmodule

bind gcr_composite_top gcr_composite_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pins       (pins),
    .rd_addr    (rd_addr),
    .phase_first(phase_first),
    .phase_last (phase_last),
    .cls        (cls),
    .look_active(look_active)
);

// File: tb/tb_gcr_composite_top.sv
module tb_gcr_composite_top;
    localparam int CPD = 2;
    localparam int HT  = 20;
    localparam int VT  = 16;
    localparam int HA  = 8;
    localparam int VA  = 6;
    localparam int HSB = 9;
    localparam int HSS = 3;
    localparam int HSL = 4;
    localparam int VSS = 10;
    localparam int VSL = 2;
    localparam int AW  = $clog2(HA * VA);
    localparam int FT  = HT * VT;
    localparam int PARK = FT - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    rd_data;
    logic [AW-1:0] rd_addr;
    logic [2:0]    pins;
    int            edges;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    gcr_composite_top #(
        .CLKS_PER_DOT(CPD), .H_TOTAL(HT), .V_TOTAL(VT),
        .H_ACTIVE(HA), .V_ACTIVE(VA),
        .HS_BASE(HSB), .HS_SHIFT(HSS), .HS_LEN(HSL),
        .VS_START(VSS), .VS_LINES(VSL)
    ) dut (
        .clk(clk), .rst(rst), .rd_data(rd_data),
        .rd_addr(rd_addr), .pins(pins)
    );

    // Image content: a permutation of all 16 codes along the address
    function automatic logic [3:0] img(input int a);
        return 4'((a * 5 + 1) % 16);
    endfunction

    // Memory model with one clock of read latency
    always @(posedge clk) rd_data <= img(int'(rd_addr));

    always @(posedge clk) edges <= rst ? 0 : edges + 1;

    function automatic logic [2:0] bin_pat(input int g);
        if (g <= 1)  return 3'b001;
        if (g <= 3)  return 3'b010;
        if (g <= 6)  return 3'b100;
        if (g <= 9)  return 3'b011;
        if (g <= 12) return 3'b101;
        return 3'b110;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, edges);
        end
    endtask

    task automatic check_cycle(input int n);
        int cur, look, lx, ly, ea, j, x, y;
        bit hw, vl, act;
        logic [2:0] ep;
        string tag;
        // R3: address of the dot after the current one
        cur  = (PARK + n / CPD) % FT;
        look = (cur + 1) % FT;
        lx = look % HT;
        ly = look / HT;
        ea = (lx < HA && ly < VA) ? ly * HA + lx : 0;
        check("R3 R2 rd_addr", int'(rd_addr), ea);
        if (n >= 1) begin
            // R4: pins lag the dot start by one clock
            j = (PARK + (n - 1) / CPD) % FT;
            x = j % HT;
            y = j / HT;
            hw  = (x >= HSB + HSS) && (x < HSB + HSS + HSL);
            vl  = (y >= VSS) && (y < VSS + VSL);
            act = (x < HA) && (y < VA);
            if (vl) begin
                ep = hw ? 3'b001 : 3'b000; tag = "R7 R4 pins";
            end else if (hw) begin
                ep = 3'b000; tag = "R6 R4 pins";
            end else if (act) begin
                ep = bin_pat(int'(img(y * HA + x))); tag = "R5 R4 pins";
            end else begin
                ep = 3'b001; tag = "R8 R4 pins";
            end
            check(tag, int'(pins), int'(ep));
        end
        // R9
        check("R9 not all high", int'(pins == 3'b111), 0);
    endtask

    task automatic check_reset(input string tag);
        check(tag, int'(pins), 1);
        check(tag, int'(rd_addr), 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check_reset("R1 reset");
        rst = 1'b0;
        // Two full frames plus a partial third
        for (int i = 0; i < 2 * FT * CPD + 150; i++) begin
            @(negedge clk);
            check_cycle(edges);
        end
        // R10: mid-frame reset
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset("R10 reset mid-frame");
        rst = 1'b0;
        for (int i = 0; i < FT * CPD + 10; i++) begin
            @(negedge clk);
            check_cycle(edges);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule